// File: doc/BRIEF.md
# Continuous-Conversion Sampling Sequencer for an I2C ADC

This block is the controller side of an I2C bus. It pulls a steady stream of 12-bit samples from an analog-to-digital converter target. After a start request it runs a fixed transaction:

1. START.
2. Write-address byte, followed by the command byte.
3. Repeated START.
4. Read-address byte, followed by two data bytes. The controller acknowledges the first data byte and refuses the second.

The controller then assembles the sample and pulses a valid strobe with it. It does not release the bus. It issues another repeated START and holds SCL still for a fixed quiet interval so the converter can settle. It then loops back to the write-address byte.

The two address-select bits, the command byte and a clock divider set the transaction. The divider sets the length of one quarter of an SCL period. If the target refuses either address byte, the cycle stops with STOP and raises a one-cycle error pulse. After a fixed back-off the block starts again with a fresh START. A stop request lets the read in progress finish, then closes the bus with STOP and returns to idle.

Both bus lines are open-drain. The block only pulls them low, and it reads SDA back from the wire.

Top module: `adcSeqTop`

## Requirements
- R1: During and right after reset, neither bus line is pulled low, and `sampleValid`, `nackErr` and `busy` are low.
- R2: Each cycle sends bytes MSB first in this order:
  - the write address {1,0,0,1,0,addrPins[1],addrPins[0],0};
  - the command byte equal to `cmdByte`;
  - a repeated START;
  - the read address, which is the same seven bits with R/W = 1.
  
  A read address is never sent before a write address has been sent.
- R3: The block reads exactly two bytes. On the first it drives ACK (SDA low on the ninth clock). On the second it leaves SDA high (NACK).
- R4: `sampleData` equals {first byte bits 3..0, second byte bits 7..0}. Bits 7..4 of the first byte have no effect. `sampleValid` is high for exactly one cycle per sample.
- R5: While running without errors, consecutive samples are joined by repeated STARTs. No STOP appears until a stop is requested.
- R6: After each looping repeated START, SCL and SDA do not change for at least QUIET_CYC system clocks before the next write address is clocked. QUIET_CYC = ceil(CLK_HZ × QUIET_NS / 10^9), which is 925 at the defaults.
- R7: Each SCL high phase inside a transaction lasts exactly 2 × (clkDiv + 1) system clocks. During address and data bits, SDA changes only while SCL is low.
- R8: If either address byte is not acknowledged, the block:
  - issues STOP;
  - pulses `nackErr` for one cycle;
  - issues the next START no sooner than RETRY_CYC clocks after that STOP.
- R9: A stop request takes effect only after the read in progress completes, including its data-valid pulse. The block then issues one STOP, drops `busy`, and issues no further START. A stop request during the back-off also returns the block to idle without a new START.
- R10: A `startReq` pulse while idle raises `busy` and produces a START condition on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Pulse: begin the sampling loop when idle |
| stopReq | input | 1 | Pulse: finish the current read, then STOP |
| addrPins | input | 2 | Target address-select bits |
| cmdByte | input | 8 | Command byte sent in every cycle |
| clkDiv | input | DIV_W | System clocks per SCL quarter, minus one |
| sdaIn | input | 1 | Level of the SDA wire |
| sclLow | output | 1 | Pull SCL low when 1 |
| sdaLow | output | 1 | Pull SDA low when 1 |
| sampleData | output | 12 | Last assembled sample |
| sampleValid | output | 1 | One-cycle strobe with a new sample |
| nackErr | output | 1 | One-cycle pulse on a refused address byte |
| busy | output | 1 | High from start until the closing STOP |

## Verification
The assertions assume three things about the inputs:
- `addrPins`, `cmdByte` and `clkDiv` stay constant while `busy` is high.
- `startReq` is only meaningful while idle.
- The wire seen on `sdaIn` is the wired-AND of the block's own pull and the target's pull.

The bench changes its configuration only between runs, after `busy` has fallen. Its target model drives SDA only after SCL has fallen. Random clock dividers, address bits, command bytes and data bytes are combined with directed refusals on each address byte and a stop request during the back-off.

// File: rtl/adcSeqPkg.sv
package adcSeqPkg;

  typedef enum logic [1:0] {
    OP_START,
    OP_STOP,
    OP_WRITE,
    OP_READ
  } opKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    go;
    opKind_t kind;
    logic [7:0] txByte;
    logic    ackOut;   // 1: pull SDA low on ninth clock of a read
  } dpCmd_t;

  // status from datapath to control
  typedef struct packed {
    logic       done;
    logic       nack;
    logic [7:0] rxByte;
  } dpStat_t;

endpackage

// File: rtl/adcSeqDatapath.sv
module adcSeqDatapath
  import adcSeqPkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] clkDiv,
  input  dpCmd_t           cmd,
  output dpStat_t          stat,
  input  logic             sdaIn,
  output logic             sclLow,
  output logic             sdaLow
);

  localparam logic [3:0] LAST_DATA_BIT = 4'd7;
  localparam logic [3:0] ACK_BIT       = 4'd8;

  logic             active;
  opKind_t          kindQ;
  logic [1:0]       quarter;
  logic [3:0]       bitIdx;
  logic [DIV_W-1:0] divCnt;
  logic [7:0]       txQ;
  logic [7:0]       rxQ;
  logic             ackQ;
  logic             nackQ;
  logic             doneQ;

  logic       tick;
  logic       lastBit;
  logic       byteOp;
  logic [1:0] nextQ;

  assign tick    = active && (divCnt == clkDiv);
  assign byteOp  = (kindQ == OP_WRITE) || (kindQ == OP_READ);
  assign lastBit = byteOp ? (bitIdx == ACK_BIT) : (bitIdx == 4'd0);
  assign nextQ   = quarter + 2'd1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      kindQ   <= OP_START;
      quarter <= '0;
      bitIdx  <= '0;
      divCnt  <= '0;
      txQ     <= '0;
      rxQ     <= '0;
      ackQ    <= 1'b0;
      nackQ   <= 1'b0;
      doneQ   <= 1'b0;
      sclLow  <= 1'b0;
      sdaLow  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (cmd.go) begin
        active  <= 1'b1;
        kindQ   <= cmd.kind;
        quarter <= '0;
        bitIdx  <= '0;
        divCnt  <= '0;
        txQ     <= cmd.txByte;
        ackQ    <= cmd.ackOut;
        case (cmd.kind)
          OP_STOP:  sdaLow <= 1'b1;
          OP_WRITE: sdaLow <= !cmd.txByte[7];
          default:  sdaLow <= 1'b0;
        endcase
      end else if (tick) begin
        divCnt <= '0;
        if (quarter == 2'd3) begin
          if (lastBit) begin
            active <= 1'b0;
            doneQ  <= 1'b1;
          end else begin
            bitIdx  <= bitIdx + 4'd1;
            quarter <= '0;
            txQ     <= {txQ[6:0], 1'b0};
            if (kindQ == OP_WRITE) begin
              sdaLow <= (bitIdx == LAST_DATA_BIT) ? 1'b0 : !txQ[6];
            end else begin
              sdaLow <= (bitIdx == LAST_DATA_BIT) ? ackQ : 1'b0;
            end
          end
        end else begin
          quarter <= nextQ;
          case (nextQ)
            2'd1: sclLow <= 1'b0;
            2'd2: begin
              if (kindQ == OP_START) begin
                sdaLow <= 1'b1;
              end else if (kindQ == OP_STOP) begin
                sdaLow <= 1'b0;
              end else if (bitIdx == ACK_BIT) begin
                nackQ <= sdaIn;
              end else begin
                rxQ <= {rxQ[6:0], sdaIn};
              end
            end
            default: begin
              if (kindQ != OP_STOP) sclLow <= 1'b1;
            end
          endcase
        end
      end else if (active) begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign stat.done   = doneQ;
  assign stat.nack   = nackQ;
  assign stat.rxByte = rxQ;

  AST_SDA_HELD_WHILE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (active && $past(active) && byteOp && $past(byteOp) && !sclLow && $past(!sclLow))
      |-> $stable(sdaLow)); // R7

  AST_LAUNCH_ONLY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    cmd.go |-> !active); // R2

endmodule

// File: rtl/adcSeqControl.sv
module adcSeqControl
  import adcSeqPkg::*;
#(
  parameter int         QUIET_CYC   = 925,
  parameter int         RETRY_CYC   = 200,
  parameter logic [4:0] ADDR_PREFIX = 5'b10010
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        stopReq,
  input  logic [1:0]  addrPins,
  input  logic [7:0]  cmdByte,
  input  dpStat_t     stat,
  output dpCmd_t      cmd,
  output logic [11:0] sampleData,
  output logic        sampleValid,
  output logic        nackErr,
  output logic        busy,
  output logic        quietActive
);

  localparam int CNT_MAX = (QUIET_CYC > RETRY_CYC) ? QUIET_CYC : RETRY_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] QUIET_LAST = CNT_W'(QUIET_CYC - 1);
  localparam logic [CNT_W-1:0] RETRY_LAST = CNT_W'(RETRY_CYC - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_WADDR, S_CMD, S_RSTART, S_RADDR,
    S_RD0, S_RD1, S_SRLOOP, S_QUIET, S_STOPERR, S_RETRY, S_STOPEND
  } state_t;

  state_t           state;
  logic             inFlight;
  logic             stopPend;
  logic [CNT_W-1:0] cnt;
  logic [3:0]       hiNibble;
  logic             isOp;

  assign isOp = !(state inside {S_IDLE, S_QUIET, S_RETRY});

  always_comb begin
    cmd        = '0;
    cmd.go     = isOp && !inFlight;
    cmd.kind   = OP_START;
    case (state)
      S_STOPERR, S_STOPEND: cmd.kind = OP_STOP;
      S_WADDR: begin
        cmd.kind   = OP_WRITE;
        cmd.txByte = {ADDR_PREFIX, addrPins, 1'b0};
      end
      S_CMD: begin
        cmd.kind   = OP_WRITE;
        cmd.txByte = cmdByte;
      end
      S_RADDR: begin
        cmd.kind   = OP_WRITE;
        cmd.txByte = {ADDR_PREFIX, addrPins, 1'b1};
      end
      S_RD0: begin
        cmd.kind   = OP_READ;
        cmd.ackOut = 1'b1;
      end
      S_RD1: cmd.kind = OP_READ;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= S_IDLE;
      inFlight    <= 1'b0;
      stopPend    <= 1'b0;
      cnt         <= '0;
      hiNibble    <= '0;
      sampleData  <= '0;
      sampleValid <= 1'b0;
      nackErr     <= 1'b0;
    end else begin
      sampleValid <= 1'b0;
      nackErr     <= 1'b0;
      if (stopReq && state != S_IDLE) stopPend <= 1'b1;
      if (cmd.go) inFlight <= 1'b1;
      case (state)
        S_IDLE: begin
          stopPend <= 1'b0;
          if (startReq) state <= S_START;
        end
        S_QUIET: begin
          if (cnt == QUIET_LAST) begin
            cnt   <= '0;
            state <= S_WADDR;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RETRY: begin
          if (stopPend || stopReq) begin
            cnt   <= '0;
            state <= S_IDLE;
          end else if (cnt == RETRY_LAST) begin
            cnt   <= '0;
            state <= S_START;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (stat.done) begin
            inFlight <= 1'b0;
            case (state)
              S_START:  state <= S_WADDR;
              S_WADDR: begin
                state   <= stat.nack ? S_STOPERR : S_CMD;
                nackErr <= stat.nack;
              end
              S_CMD:    state <= S_RSTART;
              S_RSTART: state <= S_RADDR;
              S_RADDR: begin
                state   <= stat.nack ? S_STOPERR : S_RD0;
                nackErr <= stat.nack;
              end
              S_RD0: begin
                hiNibble <= stat.rxByte[3:0];
                state    <= S_RD1;
              end
              S_RD1: begin
                sampleData  <= {hiNibble, stat.rxByte};
                sampleValid <= 1'b1;
                state       <= (stopPend || stopReq) ? S_STOPEND : S_SRLOOP;
              end
              S_SRLOOP: begin
                cnt   <= '0;
                state <= S_QUIET;
              end
              S_STOPERR: begin
                cnt   <= '0;
                state <= S_RETRY;
              end
              default: state <= S_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  assign busy        = (state != S_IDLE);
  assign quietActive = (state == S_QUIET);

  AST_VALID_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid); // R4

  AST_ERR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    nackErr |=> !nackErr); // R8

endmodule

// File: rtl/adcSeqTop.sv
module adcSeqTop
  import adcSeqPkg::*;
#(
  parameter int         CLK_HZ      = 250_000_000,
  parameter int         QUIET_NS    = 3700,
  parameter int         RETRY_CYC   = 200,
  parameter int         DIV_W       = 8,
  parameter logic [4:0] ADDR_PREFIX = 5'b10010
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             stopReq,
  input  logic [1:0]       addrPins,
  input  logic [7:0]       cmdByte,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic             sdaIn,
  output logic             sclLow,
  output logic             sdaLow,
  output logic [11:0]      sampleData,
  output logic             sampleValid,
  output logic             nackErr,
  output logic             busy
);

  localparam longint NS_PER_S  = 64'd1_000_000_000;
  localparam int     QUIET_CYC =
    int'((longint'(CLK_HZ) * longint'(QUIET_NS) + NS_PER_S - 64'd1) / NS_PER_S);

  dpCmd_t  dpCmd;
  dpStat_t dpStat;
  logic    quietActive;

  adcSeqControl #(
    .QUIET_CYC  (QUIET_CYC),
    .RETRY_CYC  (RETRY_CYC),
    .ADDR_PREFIX(ADDR_PREFIX)
  ) ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .stopReq    (stopReq),
    .addrPins   (addrPins),
    .cmdByte    (cmdByte),
    .stat       (dpStat),
    .cmd        (dpCmd),
    .sampleData (sampleData),
    .sampleValid(sampleValid),
    .nackErr    (nackErr),
    .busy       (busy),
    .quietActive(quietActive)
  );

  adcSeqDatapath #(
    .DIV_W(DIV_W)
  ) dp (
    .clk   (clk),
    .rstN  (rstN),
    .clkDiv(clkDiv),
    .cmd   (dpCmd),
    .stat  (dpStat),
    .sdaIn (sdaIn),
    .sclLow(sclLow),
    .sdaLow(sdaLow)
  );

  AST_QUIET_BUS_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (quietActive && $past(quietActive)) |-> ($stable(sclLow) && $stable(sdaLow))); // R6

  AST_IDLE_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sclLow && !sdaLow)); // R9

endmodule

// File: tb/adcSeqTop_test.sv
`timescale 1ns/1ps
module adcSeqTop_test;

  localparam int EXP_QUIET = (250 * 3700 + 999) / 1000;  // ceil(250 MHz * 3.7 us)
  localparam int RETRY     = 200;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startReq = 1'b0;
  logic       stopReq = 1'b0;
  logic [1:0] addrPins = '0;
  logic [7:0] cmdByte = '0;
  logic [7:0] clkDiv = '0;
  logic       sclLow, sdaLow, sampleValid, nackErr, busy;
  logic [11:0] sampleData;
  logic       tgtLow = 1'b0;
  logic       sclW, sdaW;

  assign sclW = !sclLow;
  assign sdaW = !(sdaLow || tgtLow);

  always #2 clk = !clk;

  adcSeqTop uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .stopReq(stopReq),
    .addrPins(addrPins), .cmdByte(cmdByte), .clkDiv(clkDiv), .sdaIn(sdaW),
    .sclLow(sclLow), .sdaLow(sdaLow), .sampleData(sampleData),
    .sampleValid(sampleValid), .nackErr(nackErr), .busy(busy)
  );

  int seqChecks = 0, seqFails = 0, monChecks = 0, monFails = 0;

  task automatic seqCheck(input bit ok, input string req, input int act, input int exp);
    seqChecks++;
    if (!ok) begin
      seqFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic monCheck(input bit ok, input string req, input int act, input int exp);
    monChecks++;
    if (!ok) begin
      monFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // stimulus-side controls
  bit nackW = 0;
  bit nackRReq = 0;

  // monitor / target-model state
  int  cyc = 0;
  bit  prevScl = 1, prevSda = 1;
  int  tState = 0;          // 0 idle, 1 address, 2 write data, 3 read data, 4 ignore
  int  bitCnt = 0;
  logic [7:0] shIn = '0;
  bit  rwBit = 0;
  bit  sawW = 0;
  int  rdIdx = 0;
  logic [7:0] drvByte = '0, byte1 = '0;
  bit  readDone = 0, loopSr = 0, loopWait = 0;
  int  fallCyc = 0, riseCyc = 0;
  bit  riseSeen = 0;
  bit  pendNackStop = 0, afterNackStop = 0;
  int  stopCyc = 0;
  int  startCnt = 0, stopCnt = 0, nackCnt = 0, errPulses = 0, sampleCnt = 0;
  bit  nackRDone = 0;
  logic [11:0] expMem [0:255];
  int  wrPtr = 0, rdPtr = 0;

  function automatic logic [7:0] expAddr(input logic [1:0] pins, input bit rw);
    return {5'b10010, pins, rw};
  endfunction

  always @(negedge clk) begin
    bit startEv, stopEv, rise, fall, doNack;
    logic [11:0] v;
    logic [3:0] junk;
    cyc++;
    startEv = prevScl && sclW && prevSda && !sdaW;
    stopEv  = prevScl && sclW && !prevSda && sdaW;
    rise    = !prevScl && sclW;
    fall    = prevScl && !sclW;
    if (rstN) begin
      if (sampleValid) begin
        monCheck(sampleData == expMem[rdPtr[7:0]], "R4 sample assembly",
                 int'(sampleData), int'(expMem[rdPtr[7:0]]));
        rdPtr++;
        sampleCnt++;
      end
      if (nackErr) errPulses++;
      if (startEv) begin
        startCnt++;
        if (afterNackStop)  // R8 back-off before retry
          monCheck(cyc - stopCyc >= RETRY, "R8 retry delay", cyc - stopCyc, RETRY);
        afterNackStop = 0;
        if (readDone) loopSr = 1;
        readDone = 0;
        tState = 1; bitCnt = 0; tgtLow = 0;
      end
      if (stopEv) begin
        stopCnt++;
        stopCyc = cyc;
        tState = 0; tgtLow = 0; riseSeen = 0; readDone = 0; sawW = 0;
        if (pendNackStop) afterNackStop = 1;
        pendNackStop = 0;
      end
      if (rise) begin
        riseSeen = 1; riseCyc = cyc;
        if (loopWait)  // R6 quiet gap
          monCheck(cyc - fallCyc >= EXP_QUIET, "R6 quiet interval", cyc - fallCyc, EXP_QUIET);
        loopWait = 0;
        if (tState >= 1 && tState <= 3) begin
          if (bitCnt < 8 && tState != 3) shIn = {shIn[6:0], sdaW};
          bitCnt++;
          if (tState == 3 && bitCnt == 9) begin
            if (rdIdx == 0) monCheck(sdaW == 1'b0, "R3 ack first byte", int'(sdaW), 0);
            else            monCheck(sdaW == 1'b1, "R3 nack second byte", int'(sdaW), 1);
          end
        end
      end
      if (fall) begin
        if (riseSeen)  // R7 SCL high time
          monCheck(cyc - riseCyc == 2 * (int'(clkDiv) + 1), "R7 scl high time",
                   cyc - riseCyc, 2 * (int'(clkDiv) + 1));
        riseSeen = 0;
        if (loopSr) begin loopSr = 0; loopWait = 1; fallCyc = cyc; end
        if (tState == 1) begin
          if (bitCnt == 8) begin
            monCheck(shIn[7:1] == expAddr(addrPins, 1'b0) >> 1, "R2 address bits",
                     int'(shIn[7:1]), int'(expAddr(addrPins, 1'b0) >> 1));
            rwBit = shIn[0];
            if (rwBit) monCheck(sawW, "R2 write address precedes read", int'(sawW), 1);
            doNack = (!rwBit && nackW) || (rwBit && nackRReq && !nackRDone);
            if (doNack) begin
              if (rwBit) nackRDone = 1;
              nackCnt++;
              pendNackStop = 1;
              tState = 4;
            end else begin
              tgtLow = 1;
              if (!rwBit) sawW = 1;
            end
          end else if (bitCnt == 9) begin
            tgtLow = 0; bitCnt = 0;
            if (!rwBit) tState = 2;
            else begin
              v = 12'($urandom);
              junk = 4'($urandom);
              expMem[wrPtr[7:0]] = v;
              wrPtr++;
              drvByte = {junk, v[11:8]};
              byte1 = v[7:0];
              rdIdx = 0;
              tState = 3;
              tgtLow = !drvByte[7];
            end
          end
        end else if (tState == 2) begin
          if (bitCnt == 8) begin
            monCheck(shIn == cmdByte, "R2 command byte", int'(shIn), int'(cmdByte));
            tgtLow = 1;
          end else if (bitCnt == 9) begin
            tgtLow = 0; tState = 4; bitCnt = 0;
          end
        end else if (tState == 3) begin
          if (bitCnt < 8) tgtLow = !drvByte[7 - bitCnt];
          else if (bitCnt == 8) tgtLow = 0;
          else begin
            if (rdIdx == 0) begin
              rdIdx = 1; drvByte = byte1; bitCnt = 0; tgtLow = !drvByte[7];
            end else begin
              tgtLow = 0; tState = 4; readDone = 1;
            end
          end
        end
      end
    end
    prevScl = sclW;
    prevSda = sdaW;
  end

  task automatic pulseStart();
    int base;
    base = startCnt;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (4 * (int'(clkDiv) + 1) + 4) @(negedge clk);
    seqCheck(busy == 1'b1, "R10 busy after start", int'(busy), 1);
    seqCheck(startCnt == base + 1, "R10 START seen", startCnt, base + 1);
  endtask

  task automatic stopAndIdle(input int expSamples, input int baseSamples,
                             input int expStops, input int baseStops);
    int st;
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    seqCheck(sampleCnt - baseSamples == expSamples, "R9 read completes before stop",
             sampleCnt - baseSamples, expSamples);
    seqCheck(stopCnt - baseStops == expStops, "R5 stops only at end",
             stopCnt - baseStops, expStops);
    seqCheck(!sclLow && !sdaLow, "R9 bus released", int'({sclLow, sdaLow}), 0);
    st = startCnt;
    repeat (400) @(negedge clk);
    seqCheck(startCnt == st, "R9 no START after stop", startCnt, st);
  endtask

  task automatic configure();
    clkDiv   = 8'($urandom % 4);
    addrPins = 2'($urandom);
    cmdByte  = 8'($urandom);
  endtask

  initial begin
    int n, bs, bst, be;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    seqCheck(!sclLow && !sdaLow, "R1 bus released in reset", int'({sclLow, sdaLow}), 0);
    seqCheck(!sampleValid && !nackErr && !busy, "R1 outputs low in reset",
             int'({sampleValid, nackErr, busy}), 0);
    rstN = 1'b1;
    @(negedge clk);
    seqCheck(!sclLow && !sdaLow && !busy, "R1 idle after reset",
             int'({sclLow, sdaLow, busy}), 0);

    // random looping runs: R2 R3 R4 R5 R6 R7
    for (int p = 0; p < 4; p++) begin
      configure();
      if (p == 0) clkDiv = 8'd0;
      n = 3 + int'($urandom % 3);
      bs = sampleCnt; bst = stopCnt;
      pulseStart();
      while (sampleCnt < bs + n) @(negedge clk);
      stopAndIdle(n + 1, bs, 1, bst);
    end

    // refused write address, then success: R8
    configure();
    nackW = 1;
    bs = sampleCnt; bst = stopCnt; be = errPulses;
    pulseStart();
    while (errPulses == be) @(negedge clk);
    nackW = 0;
    seqCheck(errPulses == be + 1, "R8 error pulse on write address", errPulses, be + 1);
    while (sampleCnt < bs + 2) @(negedge clk);
    stopAndIdle(3, bs, 2, bst);

    // refused read address once: R8
    configure();
    nackRReq = 1;
    bs = sampleCnt; bst = stopCnt; be = errPulses;
    pulseStart();
    while (sampleCnt < bs + 2) @(negedge clk);
    seqCheck(errPulses == be + 1, "R8 error pulse on read address", errPulses, be + 1);
    stopAndIdle(3, bs, 2, bst);

    // stop request during back-off: R9
    configure();
    nackW = 1;
    bs = sampleCnt; bst = stopCnt; be = errPulses;
    pulseStart();
    while (errPulses == be) @(negedge clk);
    repeat (4 * (int'(clkDiv) + 1) * 2) @(negedge clk);
    stopAndIdle(0, bs, 1, bst);
    seqCheck(errPulses == be + 1, "R8 single error before idle", errPulses, be + 1);
    nackW = 0;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***",
             seqChecks + monChecks, seqFails + monFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***",
             seqChecks + monChecks + 1, seqFails + monFails + 1);
    $finish;
  end

endmodule